// File: doc/BRIEF.md
# Camera Line Pixel Packer

This block sits behind a camera-serial-link packet decoder. It takes payload bytes from decoded long packets and turns them into pixels. It then groups the pixels into beats on an AXI4-Stream video master port. Each long packet is one image line. Every beat carries the packet's data type and virtual channel on a 10-bit destination sideband. The final beat of a line raises `m_tlast`. The first beat after a frame-start short packet on the same virtual channel raises `m_tuser[0]`.

Two pixel formats are unpacked: 8-bit and 6-bit raw. The number of pixels per beat is set by the `PPC` parameter (1, 2 or 4). Each pixel sits in a fixed slot of `SLOT_W` bits and is aligned to the top of that slot. The byte strobes mark which slot bytes hold pixels. The input cannot be stalled. A two-entry skid stage absorbs short `m_tready` stalls from downstream.

The caller must keep the average byte rate within what the output can drain. The caller must also leave the previous line time to drain, about two cycles after its last byte, before the next packet header.

Top module: `csi2_pixel_packer`

## Requirements
- R1: After reset, `m_tvalid` stays low until a line of a supported format delivers pixels.
- R2: On every beat, `m_tdest[9:4]` holds the 6-bit data type of the line's long-packet header and `m_tdest[3:0]` holds its virtual channel.
- R3: For 8-bit raw (data type 0x2A), each payload byte is one pixel, taken in arrival order. Slot 0 occupies tdata bits [SLOT_W-1:0] and slot s starts at bit s*SLOT_W. The pixel fills the top 8 bits of its slot and any lower slot bits are zero.
- R4: For 6-bit raw (data type 0x28), the payload is read as one bit stream, least significant bit of the first byte first. Pixel k is stream bits 6k..6k+5. It sits in the top 6 bits of its slot with the remaining lower bits zero. A line of N bytes yields floor(8N/6) pixels, and leftover bits are dropped.
- R5: Pixels fill slots 0 to PPC-1 in order. A beat is sent as soon as all its slots are filled, and a full beat drives every `m_tkeep` bit high.
- R6: When a line's pixel count is not a multiple of PPC, the final beat sets `m_tkeep` only for the filled slots. That is SLOT_W/8 strobe bits per slot, starting from bit 0. The tdata bits of the empty slots are zero.
- R7: `m_tlast` is high on the final beat of each line and low on every other beat.
- R8: A frame-start short packet (data type 0x00) on virtual channel v sets `m_tuser[0]` on the first beat that follows it on channel v, and on no later beat. Beats on other channels are unaffected.
- R9: While `m_tvalid` is high and `m_tready` is low, tdata, tkeep, tlast, tuser and tdest hold their values. Under back-pressure no beat is lost, duplicated or reordered, given that the input rate stays within the drain limit.
- R10: Payload bytes of a long packet whose data type is neither 0x28 nor 0x2A produce no beats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Packet header strobe, one cycle |
| hdr_dt | input | 6 | Header data type |
| hdr_vc | input | 4 | Header virtual channel |
| pay_valid | input | 1 | Payload byte strobe |
| pay_byte | input | 8 | Payload byte |
| pay_last | input | 1 | Marks the last payload byte of the packet |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Downstream ready |
| m_tdata | output | PPC*SLOT_W | Pixel slots |
| m_tkeep | output | PPC*SLOT_W/8 | Byte strobes |
| m_tlast | output | 1 | End of line |
| m_tuser | output | 1 | Start of frame |
| m_tdest | output | 10 | {data type, virtual channel} |

## Verification
The bench targets four kinds of corner case, listed here with the fault each one exposes:
- 6-bit raw lines whose length is not a multiple of three bytes. A wrong unpacker would shift a pixel across a byte seam or emit a pixel built from dropped residue bits.
- Lines of 1, 5 and 6 pixels. A design with broken strobes would mark empty slots valid or leave stale pixels in them.
- Frame starts on one channel followed by a line on another channel. A design that tracks frame start globally would tag the wrong beat.
- Stalls of one to two cycles arriving mid-line. A design without a working skid stage would change held data or drop a beat.

// File: rtl/csi2_pack_pkg.sv
package csi2_pack_pkg;
  localparam int DT_W   = 6;
  localparam int VC_W   = 4;
  localparam int DEST_W = DT_W + VC_W;
  localparam int NUM_VC = 1 << VC_W;

  localparam logic [DT_W-1:0] DT_FRAME_START = 6'h00;
  localparam logic [DT_W-1:0] DT_RAW6        = 6'h28;
  localparam logic [DT_W-1:0] DT_RAW8        = 6'h2A;
  localparam logic [DT_W-1:0] DT_LONG_MIN    = 6'h10;

  function automatic logic is_long_type(input logic [DT_W-1:0] dt);
    return dt >= DT_LONG_MIN;
  endfunction

  function automatic logic is_packed_type(input logic [DT_W-1:0] dt);
    return (dt == DT_RAW6) || (dt == DT_RAW8);
  endfunction

  // bits per pixel for a supported format
  function automatic int unsigned pixel_bits(input logic raw6);
    return raw6 ? 6 : 8;
  endfunction

  // how many whole pixels a bit store can give, capped by the slots left
  function automatic logic [1:0] pixels_ready(input int unsigned bits,
                                              input int unsigned pw,
                                              input int unsigned room);
    int unsigned n;
    n = (bits >= 2 * pw) ? 2 : ((bits >= pw) ? 1 : 0);
    if (n > room) n = room;
    return 2'(n);
  endfunction

  // pixel count of a line of nbytes bytes
  function automatic int unsigned line_pixels(input int unsigned nbytes, input logic raw6);
    return raw6 ? (nbytes * 8) / 6 : nbytes;
  endfunction

  // pixel pushed to the top of an 8-bit lane, low bits zero
  function automatic logic [7:0] lane_image(input logic [7:0] pix, input logic raw6);
    return raw6 ? {pix[5:0], 2'b00} : pix;
  endfunction
endpackage

// File: rtl/csi2_line_ctx.sv
module csi2_line_ctx
  import csi2_pack_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hdr_valid,
  input  logic [DT_W-1:0] hdr_dt,
  input  logic [VC_W-1:0] hdr_vc,
  input  logic            sof_take,
  output logic            line_open,
  output logic            line_raw6,
  output logic [DT_W-1:0] line_dt,
  output logic [VC_W-1:0] line_vc,
  output logic            line_sof
);
  logic [NUM_VC-1:0] sof_pend_q;
  logic              fs_event;
  logic              long_event;

  assign fs_event   = hdr_valid && (hdr_dt == DT_FRAME_START);
  assign long_event = hdr_valid && is_long_type(hdr_dt);

  genvar v;
  generate
    for (v = 0; v < NUM_VC; v++) begin : g_vc
      always_ff @(posedge clk) begin
        if (!rst_n)
          sof_pend_q[v] <= 1'b0;
        else if (fs_event && hdr_vc == VC_W'(v))
          sof_pend_q[v] <= 1'b1;
        else if (sof_take && line_vc == VC_W'(v))
          sof_pend_q[v] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_open <= 1'b0;
      line_raw6 <= 1'b0;
      line_dt   <= '0;
      line_vc   <= '0;
    end else if (long_event) begin
      line_open <= is_packed_type(hdr_dt);
      line_raw6 <= (hdr_dt == DT_RAW6);
      line_dt   <= hdr_dt;
      line_vc   <= hdr_vc;
    end
  end

  assign line_sof = sof_pend_q[line_vc];
endmodule

// File: rtl/csi2_pix_extract.sv
module csi2_pix_extract
  import csi2_pack_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  input  logic       byte_last,
  input  logic       raw6,
  input  logic [1:0] room_lim,
  output logic [1:0] npix,
  output logic [7:0] pix0,
  output logic [7:0] pix1,
  output logic       eol,
  output logic       acc_overflow
);
  localparam int CNT_W = $clog2(ACC_W + 9);

  logic [ACC_W-1:0] acc_q, acc_in;
  logic [CNT_W-1:0] cnt_q, cnt_in, pw, used, cnt_left;
  logic             tail_q, tail_in;

  always_comb begin
    acc_in = acc_q;
    if (byte_valid) acc_in = acc_q | (ACC_W'(byte_data) << cnt_q);
    cnt_in   = cnt_q + (byte_valid ? CNT_W'(8) : CNT_W'(0));
    pw       = CNT_W'(pixel_bits(raw6));
    npix     = pixels_ready(int'(cnt_in), int'(pw), int'(room_lim));
    used     = (npix == 2'd2) ? CNT_W'(2 * pixel_bits(raw6)) :
               (npix == 2'd1) ? pw : CNT_W'(0);
    cnt_left = cnt_in - used;
    pix0     = raw6 ? {2'b00, acc_in[5:0]}  : acc_in[7:0];
    pix1     = raw6 ? {2'b00, acc_in[11:6]} : acc_in[15:8];
    tail_in  = tail_q || (byte_valid && byte_last);
    eol      = tail_in && (cnt_left < pw);
  end

  assign acc_overflow = byte_valid && (int'(cnt_q) + 8 > ACC_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      tail_q <= 1'b0;
    end else if (eol) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      tail_q <= 1'b0;
    end else begin
      acc_q  <= acc_in >> used;
      cnt_q  <= cnt_left;
      tail_q <= tail_in;
    end
  end
endmodule

// File: rtl/csi2_beat_gather.sv
module csi2_beat_gather
  import csi2_pack_pkg::*;
#(
  parameter int PPC    = 4,
  parameter int SLOT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            npix,
  input  logic [7:0]            pix0,
  input  logic [7:0]            pix1,
  input  logic                  eol,
  input  logic                  raw6,
  input  logic [DT_W-1:0]       line_dt,
  input  logic [VC_W-1:0]       line_vc,
  input  logic                  line_sof,
  output logic [1:0]            room_lim,
  output logic                  push,
  output logic [PPC*SLOT_W-1:0] push_data,
  output logic [PPC*SLOT_W/8-1:0] push_keep,
  output logic                  push_last,
  output logic                  push_user,
  output logic [DEST_W-1:0]     push_dest,
  output logic                  sof_take
);
  localparam int DW     = PPC * SLOT_W;
  localparam int BPS    = SLOT_W / 8;
  localparam int FILL_W = $clog2(PPC + 1);

  logic [DW-1:0]     held_q;
  logic [FILL_W-1:0] fill_q, new_fill;
  int unsigned       room;

  function automatic logic [SLOT_W-1:0] slot_image(input logic [7:0] pix, input logic r6);
    return SLOT_W'(lane_image(pix, r6)) << (SLOT_W - 8);
  endfunction

  always_comb begin
    room     = PPC - int'(fill_q);
    room_lim = (room >= 2) ? 2'd2 : 2'(room);
    new_fill = fill_q + FILL_W'(npix);
    push     = (new_fill == FILL_W'(PPC)) || (eol && new_fill != '0);
  end

  genvar s;
  generate
    for (s = 0; s < PPC; s++) begin : g_slot
      logic put0, put1;
      assign put0 = (npix != 2'd0) && (int'(fill_q) == s);
      assign put1 = (npix == 2'd2) && (int'(fill_q) + 1 == s);
      assign push_data[s*SLOT_W +: SLOT_W] = put0 ? slot_image(pix0, raw6) :
                                             put1 ? slot_image(pix1, raw6) :
                                                    held_q[s*SLOT_W +: SLOT_W];
      assign push_keep[s*BPS +: BPS] = {BPS{(s < int'(new_fill))}};
    end
  endgenerate

  assign push_last = eol;
  assign push_user = line_sof;
  assign push_dest = {line_dt, line_vc};
  assign sof_take  = push && line_sof;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= '0;
      fill_q <= '0;
    end else if (push) begin
      held_q <= '0;
      fill_q <= '0;
    end else begin
      held_q <= push_data;
      fill_q <= new_fill;
    end
  end
endmodule

// File: rtl/csi2_out_skid.sv
module csi2_out_skid #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_word,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] word,
  output logic         overflow
);
  logic         v0_q, v1_q;
  logic [W-1:0] w0_q, w1_q;
  logic         pop;

  assign pop      = v0_q && ready;
  assign overflow = push && v0_q && v1_q && !pop;
  assign valid    = v0_q;
  assign word     = w0_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v0_q <= 1'b0;
      v1_q <= 1'b0;
      w0_q <= '0;
      w1_q <= '0;
    end else if (pop) begin
      if (v1_q) begin
        w0_q <= w1_q;
        v0_q <= 1'b1;
        v1_q <= push;
        if (push) w1_q <= push_word;
      end else begin
        v0_q <= push;
        if (push) w0_q <= push_word;
      end
    end else if (!v0_q) begin
      v0_q <= push;
      if (push) w0_q <= push_word;
    end else if (push && !v1_q) begin
      v1_q <= 1'b1;
      w1_q <= push_word;
    end
  end
endmodule

// File: rtl/csi2_pixel_packer.sv
module csi2_pixel_packer
  import csi2_pack_pkg::*;
#(
  parameter int PPC    = 4,
  parameter int SLOT_W = 8,
  parameter int ACC_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hdr_valid,
  input  logic [5:0]                hdr_dt,
  input  logic [3:0]                hdr_vc,
  input  logic                      pay_valid,
  input  logic [7:0]                pay_byte,
  input  logic                      pay_last,
  output logic                      m_tvalid,
  input  logic                      m_tready,
  output logic [PPC*SLOT_W-1:0]     m_tdata,
  output logic [PPC*SLOT_W/8-1:0]   m_tkeep,
  output logic                      m_tlast,
  output logic [0:0]                m_tuser,
  output logic [9:0]                m_tdest
);
  localparam int DW     = PPC * SLOT_W;
  localparam int KW     = DW / 8;
  localparam int WORD_W = DW + KW + 2 + DEST_W;

  logic              line_open, line_raw6, line_sof, sof_take;
  logic [DT_W-1:0]   line_dt;
  logic [VC_W-1:0]   line_vc;
  logic              byte_valid;
  logic [1:0]        npix, room_lim;
  logic [7:0]        pix0, pix1;
  logic              eol, acc_overflow, skid_overflow;
  logic              push, push_last, push_user;
  logic [DW-1:0]     push_data;
  logic [KW-1:0]     push_keep;
  logic [DEST_W-1:0] push_dest;
  logic [WORD_W-1:0] out_word;

  assign byte_valid = pay_valid && line_open;

  csi2_line_ctx u_ctx (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_dt(hdr_dt), .hdr_vc(hdr_vc),
    .sof_take(sof_take), .line_open(line_open), .line_raw6(line_raw6),
    .line_dt(line_dt), .line_vc(line_vc), .line_sof(line_sof)
  );

  csi2_pix_extract #(.ACC_W(ACC_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(pay_byte),
    .byte_last(pay_last), .raw6(line_raw6), .room_lim(room_lim), .npix(npix),
    .pix0(pix0), .pix1(pix1), .eol(eol), .acc_overflow(acc_overflow)
  );

  csi2_beat_gather #(.PPC(PPC), .SLOT_W(SLOT_W)) u_gather (
    .clk(clk), .rst_n(rst_n), .npix(npix), .pix0(pix0), .pix1(pix1), .eol(eol),
    .raw6(line_raw6), .line_dt(line_dt), .line_vc(line_vc), .line_sof(line_sof),
    .room_lim(room_lim), .push(push), .push_data(push_data), .push_keep(push_keep),
    .push_last(push_last), .push_user(push_user), .push_dest(push_dest), .sof_take(sof_take)
  );

  csi2_out_skid #(.W(WORD_W)) u_skid (
    .clk(clk), .rst_n(rst_n), .push(push),
    .push_word({push_data, push_keep, push_last, push_user, push_dest}),
    .ready(m_tready), .valid(m_tvalid), .word(out_word), .overflow(skid_overflow)
  );

  assign {m_tdata, m_tkeep, m_tlast, m_tuser, m_tdest} = out_word;
endmodule

// File: rtl/csi2_pixel_packer_chk.sv
module csi2_pixel_packer_chk
  import csi2_pack_pkg::*;
#(
  parameter int PPC    = 4,
  parameter int SLOT_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    m_tvalid,
  input logic                    m_tready,
  input logic [PPC*SLOT_W-1:0]   m_tdata,
  input logic [PPC*SLOT_W/8-1:0] m_tkeep,
  input logic                    m_tlast,
  input logic [0:0]              m_tuser,
  input logic [9:0]              m_tdest,
  input logic                    skid_overflow,
  input logic                    acc_overflow
);
  localparam int DW = PPC * SLOT_W;
  localparam int KW = DW / 8;

  function automatic logic [DW-1:0] raw6_low_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int s = 0; s < PPC; s++)
      for (int b = 0; b < SLOT_W - 6; b++) m[s*SLOT_W + b] = 1'b1;
    return m;
  endfunction

  function automatic logic [DW-1:0] keep_bits(input logic [KW-1:0] k);
    logic [DW-1:0] m;
    for (int b = 0; b < DW; b++) m[b] = k[b/8];
    return m;
  endfunction

  localparam logic [DW-1:0] RAW6_LOW = raw6_low_mask();

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tkeep)
      && $stable(m_tlast) && $stable(m_tuser) && $stable(m_tdest));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(skid_overflow || acc_overflow));

  // R6
  keep_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (m_tkeep != '0) && ((m_tkeep & (m_tkeep + 1'b1)) == '0));

  // R6
  partial_is_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !(&m_tkeep) |-> m_tlast);

  // R6
  empty_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (m_tdata & ~keep_bits(m_tkeep)) == '0);

  // R4
  raw6_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tdest[9:4] == DT_RAW6 |-> (m_tdata & RAW6_LOW) == '0);

  // R10
  dest_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (m_tdest[9:4] == DT_RAW6) || (m_tdest[9:4] == DT_RAW8));
endmodule

bind csi2_pixel_packer csi2_pixel_packer_chk #(.PPC(PPC), .SLOT_W(SLOT_W)) u_chk (.*);

// File: tb/csi2_pixel_packer_tb.sv
module csi2_pixel_packer_tb;
  localparam int PPC = 4;
  localparam int SLOT_W = 8;
  localparam int DW = PPC * SLOT_W;
  localparam int KW = DW / 8;
  localparam int CW = DW + KW + 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdr_valid = 1'b0;
  logic [5:0] hdr_dt = '0;
  logic [3:0] hdr_vc = '0;
  logic pay_valid = 1'b0;
  logic [7:0] pay_byte = '0;
  logic pay_last = 1'b0;
  logic m_tready = 1'b1;
  logic m_tvalid, m_tlast;
  logic [DW-1:0] m_tdata;
  logic [KW-1:0] m_tkeep;
  logic [0:0] m_tuser;
  logic [9:0] m_tdest;

  always #2 clk = ~clk;

  csi2_pixel_packer u_dut (.*);

  int n_checks = 0, n_err = 0;
  string cur_req = "R1";
  logic [CW-1:0] exp_q[0:255];
  int e_wr = 0, e_rd = 0, beats_seen = 0;
  logic [7:0] line_b[0:63];
  bit sof_exp[0:15];
  bit bp_on = 1'b0;
  int cyc = 0;
  bit hold_pend = 1'b0;
  logic [CW-1:0] hold_word;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // downstream ready pattern, driven away from the sampling edge
  always @(posedge clk) begin
    #1;
    cyc++;
    m_tready = bp_on ? !((cyc % 4) == 0 || (cyc % 7) == 0) : 1'b1;
  end

  // scoreboard and hold check, sampled on the falling edge
  always @(negedge clk) begin
    logic [CW-1:0] act;
    act = {m_tdata, m_tkeep, m_tlast, m_tuser, m_tdest};
    if (rst_n) begin
      if (hold_pend) check(m_tvalid && act == hold_word, "R9", "held beat changed", 64'(act), 64'(hold_word));
      hold_pend = m_tvalid && !m_tready;
      hold_word = act;
      if (m_tvalid && m_tready) begin
        beats_seen++;
        if (e_rd == e_wr) check(1'b0, cur_req, "unexpected beat", 64'(act), 64'(0));
        else begin
          check(act == exp_q[e_rd[7:0]], cur_req, "beat mismatch", 64'(act), 64'(exp_q[e_rd[7:0]]));
          e_rd++;
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic fill_bytes(input int n, input int seed);
    for (int i = 0; i < n; i++) line_b[i] = 8'((seed * 53) + (i * 29) ^ (i << 4));
  endtask

  // reference model: builds the expected beats of one line
  task automatic model_line(input logic [3:0] vc, input logic [5:0] dt, input int n);
    bit r6;
    int npx;
    logic [7:0] px[0:95];
    r6 = (dt == 6'h28);
    if (dt != 6'h28 && dt != 6'h2A) return;
    npx = r6 ? (n * 8) / 6 : n;
    for (int k = 0; k < npx; k++) begin
      if (r6) begin
        logic [5:0] p;
        for (int j = 0; j < 6; j++) p[j] = line_b[(6*k+j)/8][(6*k+j)%8];
        px[k] = {p, 2'b00};
      end else px[k] = line_b[k];
    end
    for (int st = 0; st < npx; st += PPC) begin
      logic [DW-1:0] d;
      logic [KW-1:0] kp;
      d = '0; kp = '0;
      for (int s = 0; s < PPC; s++)
        if (st + s < npx) begin d[s*SLOT_W +: SLOT_W] = px[st+s]; kp[s] = 1'b1; end
      exp_q[e_wr[7:0]] = {d, kp, (st + PPC >= npx), sof_exp[vc], dt, vc};
      e_wr++;
      sof_exp[vc] = 1'b0;
    end
  endtask

  task automatic send_fs(input logic [3:0] vc);
    sof_exp[vc] = 1'b1;
    hdr_valid = 1'b1; hdr_dt = 6'h00; hdr_vc = vc;
    tick();
    hdr_valid = 1'b0;
    tick();
  endtask

  task automatic send_line(input logic [3:0] vc, input logic [5:0] dt, input int n, input int gap);
    model_line(vc, dt, n);
    hdr_valid = 1'b1; hdr_dt = dt; hdr_vc = vc;
    tick();
    hdr_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      pay_valid = 1'b1; pay_byte = line_b[i]; pay_last = (i == n - 1);
      tick();
      pay_valid = 1'b0; pay_last = 1'b0;
      for (int g = 0; g < gap; g++) tick();
    end
    for (int w = 0; w < 400 && e_rd != e_wr; w++) tick();
    repeat (4) tick();
  endtask

  task automatic t_reset();
    cur_req = "R1";
    for (int i = 0; i < 3; i++) begin
      check(m_tvalid == 1'b0, "R1", "tvalid after reset", 64'(m_tvalid), 64'(0));
      tick();
    end
  endtask

  task automatic t_raw8_full();
    int b0;
    cur_req = "R3"; b0 = beats_seen;
    send_fs(4'd2);
    fill_bytes(8, 1);
    send_line(4'd2, 6'h2A, 8, 0);
    check(beats_seen - b0 == 2, "R5", "raw8 beat count", 64'(beats_seen - b0), 64'(2));
  endtask

  task automatic t_raw8_partial();
    int b0;
    cur_req = "R6"; b0 = beats_seen;
    fill_bytes(6, 2);
    send_line(4'd2, 6'h2A, 6, 0);
    fill_bytes(1, 3);
    send_line(4'd2, 6'h2A, 1, 1);
    check(beats_seen - b0 == 3, "R6", "partial beat count", 64'(beats_seen - b0), 64'(3));
  endtask

  task automatic t_dest();
    cur_req = "R2";
    send_fs(4'hF);
    fill_bytes(5, 4);
    send_line(4'hF, 6'h2A, 5, 0);
  endtask

  task automatic t_raw6();
    int b0;
    cur_req = "R4"; b0 = beats_seen;
    send_fs(4'd5);
    fill_bytes(9, 5);
    send_line(4'd5, 6'h28, 9, 0);
    fill_bytes(4, 6);
    send_line(4'd5, 6'h28, 4, 0);
    fill_bytes(7, 7);
    send_line(4'd5, 6'h28, 7, 2);
    check(beats_seen - b0 == 3 + 2 + 3, "R4", "raw6 beat count", 64'(beats_seen - b0), 64'(8));
  endtask

  task automatic t_vc_sof();
    cur_req = "R8";
    send_fs(4'd1);
    fill_bytes(4, 8);
    send_line(4'd3, 6'h2A, 4, 0);
    fill_bytes(12, 9);
    send_line(4'd1, 6'h2A, 12, 0);
    fill_bytes(4, 10);
    send_line(4'd1, 6'h2A, 4, 0);
    check(e_rd == e_wr, "R7", "all lines drained", 64'(e_rd), 64'(e_wr));
  endtask

  task automatic t_backpressure();
    cur_req = "R9";
    bp_on = 1'b1;
    send_fs(4'd0);
    fill_bytes(20, 11);
    send_line(4'd0, 6'h2A, 20, 2);
    fill_bytes(12, 12);
    send_line(4'd0, 6'h28, 12, 2);
    bp_on = 1'b0;
    repeat (4) tick();
    check(e_rd == e_wr, "R9", "beats delivered under stall", 64'(e_rd), 64'(e_wr));
  endtask

  task automatic t_unsupported();
    int b0;
    cur_req = "R10"; b0 = beats_seen;
    fill_bytes(10, 13);
    send_line(4'd0, 6'h2B, 10, 0);
    check(beats_seen == b0, "R10", "beats from unsupported type", 64'(beats_seen - b0), 64'(0));
    check(m_tvalid == 1'b0, "R10", "tvalid after unsupported line", 64'(m_tvalid), 64'(0));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    for (int v = 0; v < 16; v++) sof_exp[v] = 1'b0;
    repeat (4) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_raw8_full();
    t_raw8_partial();
    t_dest();
    t_raw6();
    t_vc_sof();
    t_backpressure();
    t_unsupported();
    finish_run();
  end
endmodule